// File: doc/BRIEF.md
# Slow Crystal Frequency Monitor

This block checks a nominal 32.768 kHz crystal clock against a faster reference clock. The crystal is sampled into the reference domain and its rising edges are counted over fixed monitoring windows, each a parameterized number of reference cycles long. At the end of every window the edge count is compared with an expected count and a tolerance band. The block keeps a count of how many bad windows have come in a row and how many edgeless windows have come in a row. From these it classifies the oscillator as GOOD, FREQ_ERROR or FAIL.

The status is sticky and is cleared when it is read through a one-cycle read strobe. When the oscillator stops outright, a one-cycle wake pulse is raised so that a sleeping system can be woken by the failure. An enable input turns monitoring on and off. While monitoring is off, no window is evaluated, but the held status is kept.

Top module: `xtal_freq_mon`

## Requirements
- R1: The status encoding is 0 = GOOD, 1 = FREQ_ERROR and 2 = FAIL. After reset the status is GOOD and the wake output is low.
- R2: While enabled, each window lasts PERIOD_CYC reference cycles and counts the rising edges of the synchronized crystal. A window is good if its count lies within EXP_EDGES ± TOL_EDGES (inclusive). A count above or below that band is bad.
- R3: FREQ_ERROR is reported at the end of the 4th consecutive bad window that still had at least one edge, and not earlier.
- R4: FAIL is reported at the end of the 2nd consecutive window with no edge, and not earlier.
- R5: A good window clears both run counts. An edgeless window clears the bad-with-edges run. A bad window with edges clears the edgeless run.
- R6: FAIL outranks FREQ_ERROR. A FAIL condition replaces a held FREQ_ERROR, and a FREQ_ERROR condition never replaces a held FAIL.
- R7: The status holds its value until a read strobe. A read with no new condition in the same cycle returns the status to GOOD on the next cycle.
- R8: When a read strobe and a window end that raises an error fall in the same cycle, the status takes the new error value.
- R9: The wake output is a one-cycle pulse, raised once when the edgeless run first reaches 2. It is not raised by FREQ_ERROR.
- R10: When disabled, the window timer and both run counts are cleared, no window ends, and the held status is kept.
- R11: The status changes only at a window end or on a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_ref_n | input | 1 | Asynchronous active-low reset |
| xtal_in | input | 1 | Crystal clock, asynchronous to clk_ref |
| mon_en | input | 1 | Monitoring enable |
| stat_rd | input | 1 | Status read strobe, clears the status |
| status_o | output | 2 | Oscillator status (0 GOOD, 1 FREQ_ERROR, 2 FAIL) |
| fail_wake_o | output | 1 | One-cycle wake pulse on crystal failure |

## Verification
The read-clear and the window-end status update can fall on the same reference edge. The bench provokes this by counting cycles from the enable: it places the read strobe exactly on the edge where the fourth slow window is judged. It then expects FREQ_ERROR to survive the read. The following read, with no window end beside it, must return GOOD. A second overlap is also tested: a stopped crystal is applied on top of a held FREQ_ERROR, and the bench checks that FAIL replaces it, while later slow windows leave FAIL in place.

// File: rtl/xfm_pkg.sv
package xfm_pkg;

  typedef enum logic [1:0] {
    XFM_GOOD     = 2'd0,
    XFM_FREQ_ERR = 2'd1,
    XFM_FAIL     = 2'd2
  } xfm_status_e;

endpackage

// File: rtl/xfm_edge_sync.sv
module xfm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nx;
  logic              last_q;
  logic              last_nx;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign sync_nx[g] = async_in;
      end else begin : g_rest
        assign sync_nx[g] = sync_q[g-1];
      end
    end
  endgenerate

  always_comb begin
    last_nx = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_nx;
      last_q <= last_nx;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/xfm_period_win.sv
module xfm_period_win #(
  parameter int PERIOD_CYC = 1024,
  parameter int CNT_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rise_i,
  output logic             done_o,
  output logic [CNT_W-1:0] edges_o
);

  localparam int TW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [TW-1:0] LAST_TICK = TW'(PERIOD_CYC - 1);

  logic [TW-1:0]    tick_q, tick_nx;
  logic [CNT_W-1:0] acc_q, acc_nx;
  logic             done_q, done_nx;
  logic [CNT_W-1:0] edges_q, edges_nx;
  logic             at_end;
  logic [CNT_W-1:0] acc_inc;

  assign at_end  = (tick_q == LAST_TICK);
  assign acc_inc = acc_q + CNT_W'(rise_i);

  always_comb begin
    tick_nx  = tick_q;
    acc_nx   = acc_q;
    done_nx  = 1'b0;
    edges_nx = edges_q;
    if (!en) begin
      tick_nx = '0;
      acc_nx  = '0;
    end else if (at_end) begin
      tick_nx  = '0;
      acc_nx   = '0;
      done_nx  = 1'b1;
      edges_nx = acc_inc;
    end else begin
      tick_nx = tick_q + TW'(1);
      acc_nx  = acc_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      acc_q   <= '0;
      done_q  <= 1'b0;
      edges_q <= '0;
    end else begin
      tick_q  <= tick_nx;
      acc_q   <= acc_nx;
      done_q  <= done_nx;
      edges_q <= edges_nx;
    end
  end

  assign done_o  = done_q;
  assign edges_o = edges_q;

  // R10
  idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !done_o);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/xfm_judge.sv
module xfm_judge
  import xfm_pkg::*;
#(
  parameter int EXP_EDGES  = 32,
  parameter int TOL_EDGES  = 2,
  parameter int BAD_LIMIT  = 4,
  parameter int DEAD_LIMIT = 2,
  parameter int CNT_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             done_i,
  input  logic [CNT_W-1:0] edges_i,
  input  logic             rd_i,
  output xfm_status_e      status_o,
  output logic             wake_o
);

  localparam int LO_EDGES = (EXP_EDGES > TOL_EDGES) ? (EXP_EDGES - TOL_EDGES) : 0;
  localparam int HI_EDGES = EXP_EDGES + TOL_EDGES;
  localparam int BW = $clog2(BAD_LIMIT + 1);
  localparam int DW = $clog2(DEAD_LIMIT + 1);
  localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO_EDGES);
  localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI_EDGES);
  localparam logic [BW-1:0] BAD_MAX  = BW'(BAD_LIMIT);
  localparam logic [DW-1:0] DEAD_MAX = DW'(DEAD_LIMIT);

  logic [BW-1:0] bad_q, bad_nx;
  logic [DW-1:0] dead_q, dead_nx;
  xfm_status_e   status_q, status_nx, base_st, evt_st;
  logic          wake_q, wake_nx;
  logic          edgeless, in_band, judge;

  assign judge    = en & done_i;
  assign edgeless = (edges_i == '0);
  assign in_band  = (edges_i >= LO_C) && (edges_i <= HI_C);

  // run counters
  always_comb begin
    bad_nx  = bad_q;
    dead_nx = dead_q;
    if (!en) begin
      bad_nx  = '0;
      dead_nx = '0;
    end else if (done_i) begin
      if (edgeless) begin
        bad_nx  = '0;
        dead_nx = (dead_q < DEAD_MAX) ? dead_q + DW'(1) : dead_q;
      end else if (!in_band) begin
        dead_nx = '0;
        bad_nx  = (bad_q < BAD_MAX) ? bad_q + BW'(1) : bad_q;
      end else begin
        bad_nx  = '0;
        dead_nx = '0;
      end
    end
  end

  // condition raised by this window
  always_comb begin
    evt_st = XFM_GOOD;
    if (judge) begin
      if (dead_nx >= DEAD_MAX) begin
        evt_st = XFM_FAIL;
      end else if (bad_nx >= BAD_MAX) begin
        evt_st = XFM_FREQ_ERR;
      end
    end
  end

  // status merge: read clears first, a higher new condition wins
  always_comb begin
    base_st   = rd_i ? XFM_GOOD : status_q;
    status_nx = base_st;
    if (judge && (logic'(evt_st > base_st))) begin
      status_nx = evt_st;
    end
    wake_nx = judge && (dead_nx == DEAD_MAX) && (dead_q != DEAD_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_q    <= '0;
      dead_q   <= '0;
      status_q <= XFM_GOOD;
      wake_q   <= 1'b0;
    end else begin
      bad_q    <= bad_nx;
      dead_q   <= dead_nx;
      status_q <= status_nx;
      wake_q   <= wake_nx;
    end
  end

  assign status_o = status_q;
  assign wake_o   = wake_q;

  // R9
  wake_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  // R9
  wake_with_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (status_o == XFM_FAIL));

  // R11
  status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_i && !rd_i) |=> $stable(status_o));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !done_i) |=> (status_o == XFM_GOOD));

  // R6
  fail_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == XFM_FAIL && !rd_i) |=> (status_o == XFM_FAIL));

  // R1
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != 2'd3));

endmodule

// File: rtl/xtal_freq_mon.sv
module xtal_freq_mon
  import xfm_pkg::*;
#(
  parameter int PERIOD_CYC  = 1024,
  parameter int EXP_EDGES   = 32,
  parameter int TOL_EDGES   = 2,
  parameter int BAD_LIMIT   = 4,
  parameter int DEAD_LIMIT  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_ref,
  input  logic       rst_ref_n,
  input  logic       xtal_in,
  input  logic       mon_en,
  input  logic       stat_rd,
  output logic [1:0] status_o,
  output logic       fail_wake_o
);

  localparam int CNT_W = $clog2(PERIOD_CYC + 1);

  logic             xtal_rise;
  logic             win_done;
  logic [CNT_W-1:0] win_edges;
  xfm_status_e      st;

  xfm_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk_ref),
    .rst_n    (rst_ref_n),
    .async_in (xtal_in),
    .rise_o   (xtal_rise)
  );

  xfm_period_win #(
    .PERIOD_CYC (PERIOD_CYC),
    .CNT_W      (CNT_W)
  ) u_win (
    .clk     (clk_ref),
    .rst_n   (rst_ref_n),
    .en      (mon_en),
    .rise_i  (xtal_rise),
    .done_o  (win_done),
    .edges_o (win_edges)
  );

  xfm_judge #(
    .EXP_EDGES  (EXP_EDGES),
    .TOL_EDGES  (TOL_EDGES),
    .BAD_LIMIT  (BAD_LIMIT),
    .DEAD_LIMIT (DEAD_LIMIT),
    .CNT_W      (CNT_W)
  ) u_judge (
    .clk      (clk_ref),
    .rst_n    (rst_ref_n),
    .en       (mon_en),
    .done_i   (win_done),
    .edges_i  (win_edges),
    .rd_i     (stat_rd),
    .status_o (st),
    .wake_o   (fail_wake_o)
  );

  assign status_o = st;

endmodule

// File: tb/test_xtal_freq_mon.sv
module test_xtal_freq_mon;

  localparam int P      = 128;
  localparam int H_GOOD = 8;
  localparam int H_SLOW = 24;
  localparam int H_FAST = 4;

  logic       clk_ref;
  logic       rst_ref_n;
  logic       xtal_in;
  logic       mon_en;
  logic       stat_rd;
  logic [1:0] status_o;
  logic       fail_wake_o;

  int checks;
  int errors;
  int wake_cnt;
  int xhalf;
  int xhalf_prev;
  int xph;
  bit finished;

  xtal_freq_mon #(
    .PERIOD_CYC (P),
    .EXP_EDGES  (8),
    .TOL_EDGES  (2),
    .BAD_LIMIT  (4),
    .DEAD_LIMIT (2)
  ) i_xtal_freq_mon (
    .clk_ref     (clk_ref),
    .rst_ref_n   (rst_ref_n),
    .xtal_in     (xtal_in),
    .mon_en      (mon_en),
    .stat_rd     (stat_rd),
    .status_o    (status_o),
    .fail_wake_o (fail_wake_o)
  );

  initial clk_ref = 1'b0;
  always #10 clk_ref = ~clk_ref;

  // crystal generator, restarts its phase when the half period changes
  always @(negedge clk_ref) begin
    if (xhalf != xhalf_prev || xhalf == 0) begin
      xph     <= 0;
      xtal_in <= 1'b0;
    end else if (xph == xhalf - 1) begin
      xph     <= 0;
      xtal_in <= ~xtal_in;
    end else begin
      xph <= xph + 1;
    end
    xhalf_prev <= xhalf;
  end

  always @(negedge clk_ref) begin
    if (fail_wake_o) wake_cnt <= wake_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  // stop monitoring, clear status, pick pattern, restart monitoring
  task automatic begin_run(input int h);
    @(negedge clk_ref);
    mon_en  = 1'b0;
    stat_rd = 1'b1;
    step(1);
    stat_rd = 1'b0;
    xhalf   = 0;
    step(4);
    wake_cnt = 0;
    xhalf  = h;
    mon_en = 1'b1;
  endtask

  task automatic do_read();
    stat_rd = 1'b1;
    step(1);
    stat_rd = 1'b0;
  endtask

  task automatic t_reset();
    check(status_o == 2'd0, "R1 reset status", status_o, 0);
    check(fail_wake_o == 1'b0, "R1 reset wake", fail_wake_o, 0);
  endtask

  task automatic t_good();
    begin_run(H_GOOD);
    step(6 * P + 4);
    check(status_o == 2'd0, "R2 in-band crystal", status_o, 0);
    check(wake_cnt == 0, "R2 no wake when good", wake_cnt, 0);
  endtask

  task automatic t_slow();
    begin_run(H_SLOW);
    step(3 * P + 4);
    check(status_o == 2'd0, "R3 three slow windows", status_o, 0);
    step(P);
    check(status_o == 2'd1, "R3 fourth slow window", status_o, 1);
    check(wake_cnt == 0, "R9 no wake on freq error", wake_cnt, 0);
    mon_en = 1'b0;
    step(300);
    check(status_o == 2'd1, "R10 status held while off", status_o, 1);
    do_read();
    check(status_o == 2'd0, "R7 read clears", status_o, 0);
  endtask

  task automatic t_fast();
    begin_run(H_FAST);
    step(4 * P + 4);
    check(status_o == 2'd1, "R2 above band is bad", status_o, 1);
  endtask

  task automatic t_dead();
    begin_run(0);
    step(P + 4);
    check(status_o == 2'd0, "R4 one edgeless window", status_o, 0);
    check(wake_cnt == 0, "R9 no wake after one", wake_cnt, 0);
    step(P);
    check(status_o == 2'd2, "R4 two edgeless windows", status_o, 2);
    check(wake_cnt == 1, "R9 wake pulse", wake_cnt, 1);
    step(3 * P);
    check(wake_cnt == 1, "R9 single wake per entry", wake_cnt, 1);
    check(status_o == 2'd2, "R4 fail persists", status_o, 2);
  endtask

  task automatic t_priority();
    begin_run(H_SLOW);
    step(4 * P);
    xhalf = 0;
    step(4);
    check(status_o == 2'd1, "R6 freq error first", status_o, 1);
    step(2 * P - 4);
    xhalf = H_SLOW;
    step(4);
    check(status_o == 2'd2, "R6 fail replaces freq error", status_o, 2);
    step(5 * P);
    check(status_o == 2'd2, "R6 freq error keeps fail", status_o, 2);
    do_read();
    check(status_o == 2'd0, "R7 read clears fail", status_o, 0);
  endtask

  task automatic t_run_reset();
    begin_run(H_SLOW);
    step(3 * P);
    xhalf = H_GOOD;
    step(P);
    xhalf = H_SLOW;
    step(3 * P + 4);
    check(status_o == 2'd0, "R5 good window clears bad run", status_o, 0);
    step(P);
    check(status_o == 2'd1, "R5 fresh run of four", status_o, 1);
    begin_run(0);
    step(P);
    xhalf = H_SLOW;
    step(P);
    xhalf = 0;
    step(P + 4);
    check(status_o == 2'd0, "R5 slow window clears edgeless run", status_o, 0);
    check(wake_cnt == 0, "R5 no wake", wake_cnt, 0);
  endtask

  task automatic t_disable();
    begin_run(H_SLOW);
    step(3 * P + 4);
    mon_en = 1'b0;
    step(50);
    mon_en = 1'b1;
    step(3 * P + 4);
    check(status_o == 2'd0, "R10 disable clears runs", status_o, 0);
  endtask

  task automatic t_same_cycle();
    begin_run(H_SLOW);
    step(4 * P);
    stat_rd = 1'b1;
    step(1);
    stat_rd = 1'b0;
    check(status_o == 2'd1, "R8 new error beats read", status_o, 1);
    do_read();
    check(status_o == 2'd0, "R7 later read clears", status_o, 0);
  endtask

  initial begin
    checks     = 0;
    errors     = 0;
    wake_cnt   = 0;
    xhalf      = 0;
    xhalf_prev = 0;
    xph        = 0;
    xtal_in    = 1'b0;
    mon_en     = 1'b0;
    stat_rd    = 1'b0;
    finished   = 1'b0;
    rst_ref_n  = 1'b0;
    step(3);
    rst_ref_n = 1'b1;
    step(2);
    t_reset();
    t_good();
    t_slow();
    t_fast();
    t_dead();
    t_priority();
    t_run_reset();
    t_disable();
    t_same_cycle();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_ref);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule